// File: doc/BRIEF.md
# Grouped Three-Channel Transfer Arbiter

This block decides which of three transfer channels owns the shared transfer engine for the next transaction. Channels 0 and 1 form a pair. Channel 2 stands alone. The arbiter works on two levels: one level chooses between the two members of the pair, and the other chooses between the pair and channel 2. Each level can be set on its own to alternate or to favour one side. A single option bit sets how a favoured side behaves. With the bit clear, the favoured side cedes one transaction to a waiting rival after it wins. With the bit set, it keeps the grant for as long as it requests.

The grant is registered and one-hot. It is held for the whole transaction. The engine pulses `done` when a transaction retires, and the arbiter then chooses again. The choice history at each level advances only when a grant retires. A host can rewrite the 8-bit setting register at any time, including in the middle of traffic. The new value takes effect from the next decision.

Top module: `grouped_dma_arbiter`

## Requirements
- R1: `grant` is zero or one-hot. A decision is made on a cycle where `done` is high or no grant is held. A decision gives the next cycle's grant to a channel that requested in the decision cycle, or gives no grant when `req` is zero. Bit n of `grant` and of `req` belongs to channel n.
- R2: Outside a decision, `grant` keeps its value whatever `req` does.
- R3: The setting register resets to 0x00. A write of `cfgWdata` with `cfgWe` high shows on `cfgRdata` one cycle later as the written value ANDed with 0x73: bits 1:0 are the pair mode, bits 5:4 are the group mode, bit 6 is the keep option, and bits 7, 3 and 2 read zero.
- R4: Pair mode 01 favours channel 1 and pair mode 10 favours channel 0. With only channels 0 and 1 requesting and the option clear, 01 gives 1,0,1,0 and 10 gives 0,1,0,1. With the option set, the favoured channel wins every time.
- R5: Group mode 01 favours channel 2 and group mode 10 favours the pair. With all channels requesting from reset, 0x10 gives 2,0,2,1 repeating, 0x11 gives 2,1,2,0 repeating, and 0x20 gives 0,1,2 repeating.
- R6: With the option clear, a pair turn in group mode 00 or 10 serves each requesting pair member once before channel 2 is served. From reset, 0x00 with all channels requesting gives 0,1,2 repeating.
- R7: With the option set and group mode 00, the groups alternate one grant each: 0x40 gives 0,2,1,2 repeating. With a favoured group, that group is served while it requests: 0x51 serves 2, then 1, then 0, as requests drop. 0x60 gives 0,1 alternating, then 2 once the pair stops requesting.
- R8: From reset, an alternating pair serves channel 0 first, and an alternating group level serves the pair first. History moves only when a grant retires.
- R9: The reserved code 11 in either mode field behaves as 00. 0x33 with all channels requesting gives 0,1,2 repeating.
- R10: A channel that drops its request is skipped with no idle decision. With 0x00, when channel 1 drops after channel 0 has been granted, the order is 0,2,0,2.
- R11: A register write while a grant is held leaves that grant in place and changes only later decisions. For example, 0x00 traffic at 0,1,2 followed by a write of 0x40 continues 2,0,2,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 3 | Request per channel |
| done | input | 1 | Current transaction retires this cycle |
| cfgWe | input | 1 | Setting register write enable |
| cfgWdata | input | 8 | Setting register write data |
| cfgRdata | output | 8 | Setting register read value |
| grant | output | 3 | One-hot grant, registered |

## Verification
The hardest state to reach from the ports is a setting change in the middle of a stream. Here the grant already held and the history left by the old mode must both carry over into the new mode, with nothing skipped and nothing repeated. The stimulus reaches it by running 0x00 traffic partway through a round and then pausing `done`. It rewrites the register while the grant is held and checks that the grant stays in place. It then resumes and checks the sequence that the history left by the old setting predicts under the new setting. Dropped requests in the middle of a stream are covered by changing `req` between retirements. A sweep over all 128 register values and all seven request patterns then checks the one-hot and requested-channel rules.

// File: rtl/grparb_pkg.sv
package grparb_pkg;
  localparam int NUM_CH = 3;
  localparam int CFG_W  = 8;
  localparam int STREAK_W = 2;
  localparam logic [CFG_W-1:0] CFG_RD_MASK = CFG_W'(8'h73);

  // 01 favours the second side, 10 the first; 00 and 11 alternate.
  typedef enum logic [1:0] {
    PRI_ALT    = 2'b00,
    PRI_SECOND = 2'b01,
    PRI_FIRST  = 2'b10,
    PRI_RSV    = 2'b11
  } prio_e;

  typedef struct packed {
    logic  keepHigh;
    prio_e grpMode;
    prio_e pairMode;
  } cfg_t;

  typedef struct packed {
    logic              issue;
    logic              clear;
    logic [NUM_CH-1:0] pick;
  } strobe_t;
endpackage

// File: rtl/grparb_cfg.sv
module grparb_cfg
  import grparb_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output cfg_t         cfg
);
  logic [1:0] pairReg;
  logic [1:0] grpReg;
  logic       keepReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairReg <= 2'b00;
      grpReg  <= 2'b00;
      keepReg <= 1'b0;
    end else if (we) begin
      pairReg <= wdata[1:0];
      grpReg  <= wdata[5:4];
      keepReg <= wdata[6];
    end
  end

  always_comb begin
    rdata        = '0;
    rdata[1:0]   = pairReg;
    rdata[5:4]   = grpReg;
    rdata[6]     = keepReg;
    cfg.keepHigh = keepReg;
    cfg.grpMode  = prio_e'(grpReg);
    cfg.pairMode = prio_e'(pairReg);
  end
endmodule

// File: rtl/grparb_ctrl.sv
module grparb_ctrl
  import grparb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] req,
  input  logic              done,
  input  logic [NUM_CH-1:0] grant,
  input  cfg_t              cfg,
  output strobe_t           strobe
);
  localparam logic [STREAK_W-1:0] STREAK_MAX = STREAK_W'(2);

  // history: last pair member served, whether that is valid,
  // whether channel 2 was served last, consecutive pair grants
  logic                lastCh, lastChValid, lastWasSolo;
  logic [STREAK_W-1:0] pairStreak;
  logic                nLastCh, nLastChValid, nLastWasSolo;
  logic [STREAK_W-1:0] nPairStreak;

  logic retire, decideNow, pairReq, soloReq, bothPair;
  logic prefCh1, innerCh1, continuePair, pickPair, usePair;

  assign retire    = done && (grant != '0);
  assign decideNow = retire || (grant == '0);
  assign pairReq   = req[0] | req[1];
  assign soloReq   = req[2];
  assign bothPair  = req[0] & req[1];

  // history as it stands once the current grant retires
  always_comb begin
    nLastCh      = lastCh;
    nLastChValid = lastChValid;
    nLastWasSolo = lastWasSolo;
    nPairStreak  = pairStreak;
    if (retire) begin
      if (grant[2]) begin
        nLastWasSolo = 1'b1;
        nPairStreak  = '0;
      end else begin
        nLastWasSolo = 1'b0;
        nLastCh      = grant[1];
        nLastChValid = 1'b1;
        if (pairStreak != STREAK_MAX) nPairStreak = pairStreak + 1'b1;
      end
    end
  end

  // pair level
  always_comb begin
    unique case (cfg.pairMode)
      PRI_SECOND: prefCh1 = cfg.keepHigh ? 1'b1 : !(nLastChValid && nLastCh);
      PRI_FIRST:  prefCh1 = cfg.keepHigh ? 1'b0 : (nLastChValid && !nLastCh);
      default:    prefCh1 = nLastChValid ? !nLastCh : 1'b0;
    endcase
    innerCh1 = bothPair ? prefCh1 : req[1];
  end

  // group level
  always_comb begin
    continuePair = (nPairStreak == '0) ||
                   ((nPairStreak == STREAK_W'(1)) && (innerCh1 != nLastCh));
    unique case (cfg.grpMode)
      PRI_SECOND: pickPair = cfg.keepHigh ? 1'b0 : nLastWasSolo;
      PRI_FIRST:  pickPair = cfg.keepHigh ? 1'b1 : continuePair;
      default:    pickPair = cfg.keepHigh ? (nPairStreak == '0) : continuePair;
    endcase
    usePair = pairReq && (!soloReq || pickPair);
  end

  always_comb begin
    strobe.issue = decideNow && (req != '0);
    strobe.clear = decideNow && (req == '0);
    if (usePair)      strobe.pick = innerCh1 ? 3'b010 : 3'b001;
    else if (soloReq) strobe.pick = 3'b100;
    else              strobe.pick = 3'b000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCh      <= 1'b1;
      lastChValid <= 1'b0;
      lastWasSolo <= 1'b0;
      pairStreak  <= '0;
    end else begin
      lastCh      <= nLastCh;
      lastChValid <= nLastChValid;
      lastWasSolo <= nLastWasSolo;
      pairStreak  <= nPairStreak;
    end
  end
endmodule

// File: rtl/grparb_dp.sv
module grparb_dp
  import grparb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic [NUM_CH-1:0] grant
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             grant <= '0;
    else if (strobe.issue) grant <= strobe.pick;
    else if (strobe.clear) grant <= '0;
  end
endmodule

// File: rtl/grouped_dma_arbiter.sv
module grouped_dma_arbiter
  import grparb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] req,
  input  logic              done,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  output logic [NUM_CH-1:0] grant
);
  cfg_t    cfg;
  strobe_t strobe;

  grparb_cfg #(.W(CFG_W)) uCfg (
    .clk(clk), .rstN(rstN), .we(cfgWe), .wdata(cfgWdata),
    .rdata(cfgRdata), .cfg(cfg)
  );

  grparb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .req(req), .done(done),
    .grant(grant), .cfg(cfg), .strobe(strobe)
  );

  grparb_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grant(grant)
  );
endmodule

// File: rtl/grouped_dma_arbiter_chk.sv
module grouped_dma_arbiter_chk
  import grparb_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] req,
  input logic              done,
  input logic              cfgWe,
  input logic [CFG_W-1:0]  cfgWdata,
  input logic [CFG_W-1:0]  cfgRdata,
  input logic [NUM_CH-1:0] grant
);
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_grant_to_requester_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((done || grant == '0) && req != '0) |=> ((grant & $past(req)) != '0));

  assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((done || grant == '0) && req == '0) |=> (grant == '0));

  assert_grant_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && !done) |=> (grant == $past(grant)));

  assert_cfg_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (cfgRdata == ($past(cfgWdata) & CFG_RD_MASK)));

  assert_cfg_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgRdata));
endmodule

bind grouped_dma_arbiter grouped_dma_arbiter_chk uChk (
  .clk(clk), .rstN(rstN), .req(req), .done(done), .cfgWe(cfgWe),
  .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .grant(grant)
);

// File: tb/grouped_dma_arbiter_test.sv
module grouped_dma_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] req = '0;
  logic       done = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic [7:0] cfgRdata;
  logic [2:0] grant;
  int tests = 0;
  int fails = 0;

  grouped_dma_arbiter uut (
    .clk(clk), .rstN(rstN), .req(req), .done(done), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; req = '0; done = 1'b0; cfgWe = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // check the grant now held, then retire it at the next edge
  task automatic step(input int e, input string tag);
    chk(grant == 3'(1 << e), tag, 8'(grant), 8'(1 << e));
    done = 1'b1;
    @(negedge clk);
  endtask

  task automatic startAll(input logic [7:0] v, input logic [2:0] r);
    doReset();
    writeCfg(v);
    req = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    $display("FAIL watchdog expired (all requirements)");
    fails++;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // reset state, R3 and R1
    doReset();
    chk(cfgRdata == 8'h00, "R3 reset value", cfgRdata, 8'h00);
    repeat (3) @(negedge clk);
    chk(grant == 3'b000, "R1 no request no grant", 8'(grant), 8'h00);
    writeCfg(8'hFF);
    chk(cfgRdata == 8'h73, "R3 readback mask", cfgRdata, 8'h73);
    writeCfg(8'h5A);
    chk(cfgRdata == 8'h52, "R3 readback fields", cfgRdata, 8'h52);

    // R6 and R8: alternating both levels, option clear
    startAll(8'h00, 3'b111);
    step(0, "R8 first pick"); step(1, "R6"); step(2, "R6");
    step(0, "R6"); step(1, "R6"); step(2, "R6");

    // R7: option set, alternating groups
    startAll(8'h40, 3'b111);
    step(0, "R7"); step(2, "R7"); step(1, "R7"); step(2, "R7"); step(0, "R7"); step(2, "R7");

    // R5: group modes
    startAll(8'h10, 3'b111);
    step(2, "R5 0x10"); step(0, "R5 0x10"); step(2, "R5 0x10"); step(1, "R5 0x10"); step(2, "R5 0x10");
    startAll(8'h11, 3'b111);
    step(2, "R5 0x11"); step(1, "R5 0x11"); step(2, "R5 0x11"); step(0, "R5 0x11"); step(2, "R5 0x11");
    startAll(8'h20, 3'b111);
    step(0, "R5 0x20"); step(1, "R5 0x20"); step(2, "R5 0x20"); step(0, "R5 0x20");

    // R7: favoured group keeps the grant
    startAll(8'h51, 3'b111);
    step(2, "R7 0x51"); step(2, "R7 0x51");
    req = 3'b011;
    step(2, "R7 0x51"); step(1, "R7 0x51"); step(1, "R7 0x51");
    req = 3'b001;
    step(1, "R7 0x51"); step(0, "R7 0x51"); step(0, "R7 0x51");
    startAll(8'h50, 3'b111);
    step(2, "R7 0x50"); step(2, "R7 0x50");
    req = 3'b011;
    step(2, "R7 0x50"); step(0, "R7 0x50"); step(1, "R7 0x50"); step(0, "R7 0x50");
    startAll(8'h60, 3'b111);
    step(0, "R7 0x60"); step(1, "R7 0x60"); step(0, "R7 0x60");
    req = 3'b100;
    step(1, "R7 0x60"); step(2, "R7 0x60"); step(2, "R7 0x60");

    // R4: pair modes
    startAll(8'h01, 3'b011);
    step(1, "R4 0x01"); step(0, "R4 0x01"); step(1, "R4 0x01"); step(0, "R4 0x01");
    startAll(8'h02, 3'b011);
    step(0, "R4 0x02"); step(1, "R4 0x02"); step(0, "R4 0x02"); step(1, "R4 0x02");
    startAll(8'h61, 3'b011);
    step(1, "R4 0x61"); step(1, "R4 0x61"); step(1, "R4 0x61");
    startAll(8'h62, 3'b111);
    step(0, "R4 0x62"); step(0, "R4 0x62"); step(0, "R4 0x62");

    // R9: reserved codes alternate
    startAll(8'h33, 3'b111);
    step(0, "R9"); step(1, "R9"); step(2, "R9"); step(0, "R9"); step(1, "R9"); step(2, "R9");

    // R10: withdrawn request skipped
    startAll(8'h00, 3'b111);
    req = 3'b101;
    step(0, "R10"); step(2, "R10"); step(0, "R10"); step(2, "R10");

    // R2: grant held without done, whatever req does
    startAll(8'h00, 3'b111);
    req = 3'b110;
    @(negedge clk); @(negedge clk);
    chk(grant == 3'b001, "R2 hold", 8'(grant), 8'h01);
    step(0, "R2 hold"); step(1, "R2 after hold");

    // R11: reprogram mid-stream with a grant held
    startAll(8'h00, 3'b111);
    step(0, "R11"); step(1, "R11");
    done = 1'b0;
    writeCfg(8'h40);
    @(negedge clk);
    chk(grant == 3'b100, "R11 grant kept across write", 8'(grant), 8'h04);
    step(2, "R11"); step(0, "R11"); step(2, "R11"); step(1, "R11");
    done = 1'b0;

    // R1 sweep over every setting and request pattern
    for (int c = 0; c < 128; c++) begin
      for (int r = 1; r < 8; r++) begin
        startAll(8'(c), 3'(r));
        for (int k = 0; k < 4; k++) begin
          chk($onehot(grant) && ((grant & 3'(r)) != 3'b000), "R1 sweep",
              8'(grant), 8'(r));
          done = 1'b1;
          @(negedge clk);
        end
        done = 1'b0;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule